// File: doc/BRIEF.md
# Direct-Mapped Write-Through Byte Cache

This block sits between a processor port and a main-memory port and keeps recently used 4-byte lines of a 24-bit byte-addressed space. Each address picks exactly one line, given by the block number modulo the line count. A read compares that line's stored tag and valid bit. On a hit the addressed byte comes back one cycle after the request. On a miss the whole line is fetched from memory and installed, and only then is the byte returned. There is no choice of victim: a fill always overwrites the single indexed line.

Every store goes to memory, so memory never holds stale data. A store that hits also updates the cached byte. A store that misses leaves the cache untouched, so no line is allocated on a write. The processor sees a single ready signal. It is low while a fill or a write to memory is outstanding. The memory port uses a request/acknowledge handshake that carries a 22-bit block address, a 32-bit line and a 4-bit byte-lane mask.

The controller is a three-state machine:
- `ST_IDLE`: accepts requests and answers read hits.
- `ST_FILL`: fetches the line for a read miss.
- `ST_WRITE`: sends a store to memory.

Its transitions are:
- IDLE→IDLE on an idle cycle or a read hit.
- IDLE→FILL on a read miss.
- IDLE→WRITE on any store.
- FILL→IDLE on acknowledge, which installs the line and answers.
- WRITE→IDLE on acknowledge.

The number of index bits `IDX_W` is a parameter. The byte offset is always bits 1:0, the index is bits IDX_W+1:2, and the tag is the bits above the index. With IDX_W = 14 this gives an 8-bit tag in bits 23:16 and a 14-bit index in bits 15:2.

Top module: `wt_cache_dm`

## Requirements
- R1: Reset clears every valid bit. After reset `cpu_ready` is 1, `mem_req` is 0 and `cpu_rvalid` is 0, and the first read of any address misses.
- R2: Address fields are: offset = bits 1:0, index = bits IDX_W+1:2, tag = bits 23:IDX_W+2. `mem_blk_addr` equals bits 23:2 of the accepted address. Byte k of a line is bits 8k+7:8k of `mem_rdata`, and the read returns byte k for offset k.
- R3: A read that hits (valid line, equal tag) raises `cpu_rvalid` with the byte in the cycle after acceptance. It issues no memory request.
- R4: A read miss issues one read request (`mem_we` = 0, `mem_be` = 4'hF) with `cpu_ready` low until the acknowledge. The line is installed at the acknowledge, and `cpu_rvalid` rises in the cycle after it with the requested byte.
- R5: Two blocks with the same index and different tags evict each other. A read of the older one after the newer is filled misses.
- R6: Every store issues one write request: `mem_we` = 1, `mem_be` one-hot at bit offset, the byte replicated in all four lanes of `mem_wdata`. `cpu_ready` stays low until the acknowledge.
- R7: A store that hits updates the cached byte, so a later read of that address hits and returns the new byte.
- R8: A store that misses does not allocate: a later read of that address misses and fetches from memory.
- R9: While `mem_req` is high and not acknowledged, `mem_req`, `mem_we` and `mem_blk_addr` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 24 | Byte address |
| cpu_wdata | input | 8 | Store byte |
| cpu_ready | output | 1 | Request accepted when high together with cpu_valid |
| cpu_rvalid | output | 1 | Load data valid, one-cycle pulse |
| cpu_rdata | output | 8 | Load byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write request, 0 = line read |
| mem_blk_addr | output | 22 | Block address (byte address bits 23:2) |
| mem_be | output | 4 | Byte lanes written |
| mem_wdata | output | 32 | Write data, byte replicated in every lane |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | 32 | Line returned with acknowledge |

## Verification
A store that hits does two things at the same acceptance edge: it writes the byte into the data array, and it launches the write-through request from the same captured address and byte. The bench provokes this by storing to lines it has just made resident. It judges the memory side from the lane mask, the block address and the byte captured at the acknowledge. It judges the cache side by a following read that must return the new byte one cycle after acceptance, with no line fetch. Randomised mixes over four tags and all lines of a 16-line configuration repeat this overlap next to misses, evictions and non-allocating stores.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
    localparam int ADDR_W = 24;
    localparam int OFS_W  = 2;
    localparam int BLK_W  = ADDR_W - OFS_W;
    localparam int LINE_W = 8 << OFS_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_WRITE = 2'd2
    } wtc_state_e;
endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
    parameter int IDX_W = 10,
    parameter int TAG_W = 12,
    localparam int LINES = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             hit,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);
    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
        end
    end

    assign hit = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
endmodule

// File: rtl/wtc_data_store.sv
module wtc_data_store
    import wtc_pkg::*;
#(
    parameter int IDX_W = 10,
    localparam int LINES = 1 << IDX_W,
    localparam int NBYTE = 1 << OFS_W
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [LINE_W-1:0] rd_line,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              byte_en,
    input  logic [IDX_W-1:0]  byte_idx,
    input  logic [OFS_W-1:0]  byte_ofs,
    input  logic [7:0]        byte_val
);
    logic [LINE_W-1:0] line_q [LINES];

    always_ff @(posedge clk) begin
        if (fill_en) begin
            line_q[fill_idx] <= fill_line;
        end else if (byte_en) begin
            for (int k = 0; k < NBYTE; k++) begin
                if (byte_ofs == OFS_W'(k)) begin
                    line_q[byte_idx][8*k +: 8] <= byte_val;
                end
            end
        end
    end

    assign rd_line = line_q[rd_idx];
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
    import wtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_valid,
    input  logic cpu_we,
    input  logic hit,
    input  logic mem_ack,
    output logic cpu_ready,
    output logic accept,
    output logic mem_req,
    output logic mem_we,
    output logic fill_done
);
    wtc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (cpu_we)   state_d = ST_WRITE;
                    else if (!hit) state_d = ST_FILL;
                end
            end
            ST_FILL:  if (mem_ack) state_d = ST_IDLE;
            ST_WRITE: if (mem_ack) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cpu_ready = 1'b0;
        accept    = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        fill_done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cpu_ready = 1'b1;
                accept    = cpu_valid;
            end
            ST_FILL: begin
                mem_req   = 1'b1;
                fill_done = mem_ack;
            end
            ST_WRITE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/wt_cache_dm.sv
module wt_cache_dm
    import wtc_pkg::*;
#(
    parameter int IDX_W = 10,
    localparam int TAG_W = BLK_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_rvalid,
    output logic [7:0]        cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [BLK_W-1:0]  mem_blk_addr,
    output logic [3:0]        mem_be,
    output logic [LINE_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [LINE_W-1:0] mem_rdata
);
    logic              accept, hit, fill_done, rd_hit;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        wbyte_q;
    logic [LINE_W-1:0] cur_line;

    wire [IDX_W-1:0] cpu_idx = cpu_addr[OFS_W +: IDX_W];
    wire [TAG_W-1:0] cpu_tag = cpu_addr[ADDR_W-1 -: TAG_W];
    wire [OFS_W-1:0] cpu_ofs = cpu_addr[OFS_W-1:0];
    wire [IDX_W-1:0] q_idx   = addr_q[OFS_W +: IDX_W];
    wire [TAG_W-1:0] q_tag   = addr_q[ADDR_W-1 -: TAG_W];
    wire [OFS_W-1:0] q_ofs   = addr_q[OFS_W-1:0];

    wtc_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_valid (cpu_valid),
        .cpu_we    (cpu_we),
        .hit       (hit),
        .mem_ack   (mem_ack),
        .cpu_ready (cpu_ready),
        .accept    (accept),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .fill_done (fill_done)
    );

    wtc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (cpu_idx),
        .rd_tag (cpu_tag),
        .hit    (hit),
        .wr_en  (fill_done),
        .wr_idx (q_idx),
        .wr_tag (q_tag)
    );

    wtc_data_store #(.IDX_W(IDX_W)) u_data (
        .clk       (clk),
        .rd_idx    (cpu_idx),
        .rd_line   (cur_line),
        .fill_en   (fill_done),
        .fill_idx  (q_idx),
        .fill_line (mem_rdata),
        .byte_en   (accept && cpu_we && hit),
        .byte_idx  (cpu_idx),
        .byte_ofs  (cpu_ofs),
        .byte_val  (cpu_wdata)
    );

    assign rd_hit = accept && !cpu_we && hit;

    always_ff @(posedge clk) begin
        if (accept) begin
            addr_q  <= cpu_addr;
            wbyte_q <= cpu_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_rvalid <= 1'b0;
            cpu_rdata  <= '0;
        end else begin
            cpu_rvalid <= rd_hit || fill_done;
            if (fill_done)   cpu_rdata <= mem_rdata[{q_ofs, 3'b000} +: 8];
            else if (rd_hit) cpu_rdata <= cur_line[{cpu_ofs, 3'b000} +: 8];
        end
    end

    assign mem_blk_addr = addr_q[ADDR_W-1:OFS_W];
    assign mem_be       = mem_we ? (4'b0001 << q_ofs) : 4'b1111;
    assign mem_wdata    = {4{wbyte_q}};
endmodule

// File: rtl/wtc_chk.sv
module wtc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_ready,
    input logic        cpu_rvalid,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ack,
    input logic [3:0]  mem_be,
    input logic [21:0] mem_blk_addr
);
    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_blk_addr)));

    // R4
    ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cpu_ready);

    // R6
    wr_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> ($countones(mem_be) == 1));

    // R4
    rd_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> (mem_be == 4'hF));

    // R4
    fill_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |=> cpu_rvalid);
endmodule

bind wt_cache_dm wtc_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_ready    (cpu_ready),
    .cpu_rvalid   (cpu_rvalid),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_ack      (mem_ack),
    .mem_be       (mem_be),
    .mem_blk_addr (mem_blk_addr)
);

// File: tb/tb_wt_cache_dm.sv
module tb_wt_cache_dm;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W = 4;
    localparam int LINES = 1 << IDX_W;
    localparam int TAG_W = 22 - IDX_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_valid = 1'b0, cpu_we = 1'b0;
    logic [23:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_ready, cpu_rvalid;
    logic [7:0]  cpu_rdata;
    logic        mem_req, mem_we;
    logic [21:0] mem_blk_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0, errors = 0;
    bit done = 0;

    wt_cache_dm #(.IDX_W(IDX_W)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // memory model
    logic [7:0]  wmem [int];
    int          n_rd = 0, n_wr = 0, wait_cnt = 0;
    logic [21:0] last_rd_blk, last_wr_blk;
    logic [3:0]  last_wr_be;
    logic [31:0] last_wr_data;

    function automatic logic [7:0] base_byte(logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ {a[20:16], a[23:21]} ^ 8'h5A;
    endfunction

    function automatic logic [7:0] mem_byte(logic [23:0] a);
        if (wmem.exists(int'(a))) return wmem[int'(a)];
        return base_byte(a);
    endfunction

    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (wait_cnt >= ((n_rd + n_wr) % 3)) begin
                    wait_cnt = 0;
                    mem_ack = 1'b1;
                    if (mem_we) begin
                        n_wr++;
                        last_wr_blk = mem_blk_addr;
                        last_wr_be = mem_be;
                        last_wr_data = mem_wdata;
                        for (int k = 0; k < 4; k++)
                            if (mem_be[k]) wmem[int'({mem_blk_addr, 2'(k)})] = mem_wdata[8*k +: 8];
                    end else begin
                        n_rd++;
                        last_rd_blk = mem_blk_addr;
                        for (int k = 0; k < 4; k++)
                            mem_rdata[8*k +: 8] = mem_byte({mem_blk_addr, 2'(k)});
                    end
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    // bench-side expectation of residency
    bit               ev [LINES];
    logic [TAG_W-1:0] et [LINES];

    function automatic logic [23:0] mk(int tg, int idx, int ofs);
        return {TAG_W'(tg), IDX_W'(idx), 2'(ofs)};
    endfunction

    task automatic do_read(input logic [23:0] a, output logic [7:0] d,
                           output int lat, output bit missed);
        int r0;
        while (!cpu_ready) @(negedge clk);
        r0 = n_rd;
        cpu_valid = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        @(negedge clk);
        cpu_valid = 1'b0;
        lat = 1;
        while (!cpu_rvalid) begin @(negedge clk); lat++; end
        d = cpu_rdata;
        missed = (n_rd != r0);
    endtask

    task automatic chk_read(input logic [23:0] a, input string lbl);
        logic [7:0] d; int lat; bit missed, exp_miss;
        int idx = int'(a[2 +: IDX_W]);
        logic [TAG_W-1:0] tg = a[23 -: TAG_W];
        exp_miss = !(ev[idx] && et[idx] == tg);
        do_read(a, d, lat, missed);
        check(missed == exp_miss, lbl, "miss flag", missed, exp_miss);
        check(d == mem_byte(a), "R2", "read byte", d, mem_byte(a));
        if (exp_miss) begin
            check(last_rd_blk == a[23:2], "R2", "fill block addr", last_rd_blk, a[23:2]);
            ev[idx] = 1'b1; et[idx] = tg;
        end else begin
            check(lat == 1, "R3", "hit latency", lat, 1);
        end
    endtask

    task automatic chk_write(input logic [23:0] a, input logic [7:0] w);
        int w0; bit low;
        while (!cpu_ready) @(negedge clk);
        w0 = n_wr;
        cpu_valid = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = w;
        @(negedge clk);
        cpu_valid = 1'b0;
        low = !cpu_ready;
        while (!cpu_ready) @(negedge clk);
        check(low, "R6", "ready low during store", cpu_ready, 0);
        check(n_wr == w0 + 1, "R6", "write requests", n_wr - w0, 1);
        check(last_wr_blk == a[23:2], "R6", "write block addr", last_wr_blk, a[23:2]);
        check(last_wr_be == (4'b0001 << a[1:0]), "R6", "lane mask", last_wr_be, 4'b0001 << a[1:0]);
        check(last_wr_data[8*a[1:0] +: 8] == w, "R6", "write byte", last_wr_data[8*a[1:0] +: 8], w);
    endtask

    initial begin
        logic [31:0] seed = 32'h1234_5678;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle after reset
        check(cpu_ready == 1'b1, "R1", "ready after reset", cpu_ready, 1);
        check(mem_req == 1'b0, "R1", "no request after reset", mem_req, 0);
        check(cpu_rvalid == 1'b0, "R1", "no rvalid after reset", cpu_rvalid, 0);

        // R1/R4: cold sweep, every line misses
        for (int i = 0; i < LINES; i++) chk_read(mk(3, i, i % 4), "R1");
        // R3/R2: every byte of every resident line hits
        for (int i = 0; i < LINES; i++)
            for (int o = 0; o < 4; o++) chk_read(mk(3, i, o), "R3");
        // R5: conflicting blocks evict each other
        for (int i = 0; i < LINES; i += 3) begin
            chk_read(mk(5, i, 1), "R5");
            chk_read(mk(3, i, 2), "R5");
        end
        // R6/R7: store hits, then read back without fill
        for (int i = 0; i < LINES; i++) begin
            chk_write(mk(3, i, (i + 1) % 4), 8'(i * 37 + 11));
            chk_read(mk(3, i, (i + 1) % 4), "R7");
        end
        // R8: store misses do not allocate
        for (int i = 0; i < LINES; i += 2) begin
            chk_write(mk(9, i, 3), 8'(i + 200));
            chk_read(mk(9, i, 3), "R8");
        end
        // mixed traffic
        for (int n = 0; n < 600; n++) begin
            logic [23:0] a;
            seed = seed * 32'd1664525 + 32'd1013904223;
            a = mk(int'(seed[29:28]), int'(seed[23:20]), int'(seed[17:16]));
            if (seed[9:8] == 2'b00) chk_write(a, seed[7:0]);
            else chk_read(a, "R4");
        end
        done = 1;
        summary();
        $finish;
    end
endmodule